// File: doc/BRIEF.md
# Five-Cluster Interleaved SEC-DED Link Decoder

This block sits at the receiving end of a wide on-chip link that carries every 32-bit flit five times. The sender protects each copy with an extended Hamming code and interleaves the five copies across the wires. The decoder takes a 195-bit link word and splits it back into five 39-bit clusters. Each cluster goes through its own single-error-correcting, double-error-detecting decoder. A selection stage then builds one 32-bit flit by a bitwise majority vote.

Each cluster decoder returns its corrected data, a flag saying it saw any error, and a flag saying it saw a double error. The selector runs in one of three named modes. In SEL_CLEAN it votes only among clusters with no double-error flag, and it uses this mode when at least three clusters are clean. In SEL_ALL it votes across all five clusters, and it uses this mode when one or two clusters are clean. In SEL_NONE no cluster is clean. The mode is chosen again for every word from the double-error flags alone, so it carries no history between words. The voted flit and two status flags are captured in one output register. Valid therefore comes out one clock after it goes in.

A cluster codeword has 39 bits. Bit 0 is the overall parity, equal to the XOR of all 39 bits (even parity). Bits 1 to 38 are in Hamming order, with check bits at positions 1, 2, 4, 8, 16 and 32. Data bit i sits at the i-th position that is not a power of two, in ascending order, so data bit 0 is at position 3. Check bit 2^k makes the XOR over all positions whose index has bit k set equal to zero. Wire w of the link word carries bit (w div 5) of cluster (w mod 5), so any three adjacent wires fall in three different clusters.

Top module: `penta_link_decoder`

## Requirements
- R1: With the codeword layout and wire interleaving given above and no wire in error, out_data equals the flit that was sent, and both flags are low.
- R2: After reset out_valid, out_data and both flags are zero. out_valid equals in_valid one cycle later. Both flags are zero whenever out_valid is low. out_data holds its value in any cycle after in_valid was low.
- R3: A single flipped wire anywhere among the 195 is corrected. The result has the sent data, out_corrected high and out_uncorrectable low.
- R4: Three flipped adjacent wires, at any start position, are corrected, with out_corrected high and out_uncorrectable low.
- R5: A cluster with exactly two flipped bits raises its double-error flag and is left out of the clean-cluster vote.
- R6: Up to nine flipped wires are corrected when at least three clusters hold at most one error each, the other two holding any number. The result has out_corrected high and out_uncorrectable low.
- R7: With three or more clean clusters, each output bit is the majority of the clean clusters. A vote that is not unanimous raises out_corrected even when no cluster saw a code error.
- R8: With one or two clean clusters, each output bit is the majority of all five clusters.
- R9: out_uncorrectable rises when all five clusters flag a double error, and out_corrected then stays low.
- R10: out_uncorrectable rises when the clean clusters split evenly on any bit, and out_corrected is low whenever out_uncorrectable is high.
- R11: out_corrected is high exactly when the result is not uncorrectable and either some cluster saw a code error or some vote was not unanimous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Link word present this cycle |
| in_word | input | 195 | Interleaved received link word |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_data | output | 32 | Recovered flit |
| out_corrected | output | 1 | Result needed correction or an outvote |
| out_uncorrectable | output | 1 | No reliable result |

## Verification
Clean words with several data values check the codeword layout and the wire mapping, since any mismatch there shows up as wrong data on an error-free word. An error on each of the 195 wires in turn, and a three-wire burst at every start position, show that the interleave and the per-cluster single-error correction reach every bit. Random patterns of up to nine errors put one cluster under heavy errors and one cluster under a double error. These separate correct vote masking from a naive vote that would count miscorrected or flagged copies. Directed words build clusters with different data to drive each selector mode, a tied clean vote, an all-flagged word and a unanimous-but-split vote. This distinguishes the SEL_CLEAN, SEL_ALL and SEL_NONE paths and the two flag rules.

// File: rtl/penta_dec_pkg.sv
package penta_dec_pkg;

    // selection mode of the voting stage
    typedef enum logic [1:0] {
        SEL_CLEAN = 2'd0,
        SEL_ALL   = 2'd1,
        SEL_NONE  = 2'd2
    } sel_mode_e;

    function automatic bit is_pow2(input int v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

    // number of Hamming check bits for a data width
    function automatic int check_bits(input int dw);
        int p;
        p = 0;
        while ((1 << p) < dw + p + 1) p++;
        return p;
    endfunction

    // codeword position of data bit idx (non power-of-two positions, ascending)
    function automatic int data_pos(input int idx);
        int seen;
        int pos;
        seen = -1;
        pos  = 0;
        while (seen < idx) begin
            pos++;
            if (!is_pow2(pos)) seen++;
        end
        return pos;
    endfunction

endpackage

// File: rtl/cluster_splitter.sv
module cluster_splitter #(
    parameter int NUM_CL = 5,
    parameter int CW_W   = 39,
    localparam int LINK_W = NUM_CL * CW_W
) (
    input  logic [LINK_W-1:0]             link_word,
    output logic [NUM_CL-1:0][CW_W-1:0]   cl_word
);

    // wire j*NUM_CL + c carries bit j of cluster c
    for (genvar c = 0; c < NUM_CL; c++) begin : g_cl
        for (genvar j = 0; j < CW_W; j++) begin : g_bit
            assign cl_word[c][j] = link_word[j*NUM_CL + c];
        end
    end

endmodule

// File: rtl/secded_cluster_dec.sv
module secded_cluster_dec
    import penta_dec_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int CHK_W = check_bits(DATA_W),
    localparam int CW_W  = DATA_W + CHK_W + 1
) (
    input  logic [CW_W-1:0]   cw,
    output logic [DATA_W-1:0] data,
    output logic              err_seen,
    output logic              dbl_err
);

    logic [CHK_W-1:0]  syn;
    logic              par_odd;
    logic [DATA_W-1:0] err_vec;

    // syndrome: XOR of received bits per index bit
    always_comb begin
        syn = '0;
        for (int p = 1; p < CW_W; p++) begin
            for (int k = 0; k < CHK_W; k++) begin
                if (((p >> k) & 1) == 1) syn[k] = syn[k] ^ cw[p];
            end
        end
    end

    assign par_odd = ^cw;

    // error vector: AND tree of syndrome against each position, gated by odd parity
    for (genvar i = 0; i < DATA_W; i++) begin : g_fix
        localparam int POS = data_pos(i);
        localparam logic [CHK_W-1:0] PV = CHK_W'(POS);
        assign err_vec[i] = par_odd & (&(syn ~^ PV));
        assign data[i]    = cw[POS] ^ err_vec[i];
    end

    assign err_seen = par_odd | (|syn);
    assign dbl_err  = (|syn) & ~par_odd;

endmodule

// File: rtl/cluster_vote_select.sv
module cluster_vote_select
    import penta_dec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM_CL = 5,
    localparam int MAJ   = NUM_CL / 2 + 1
) (
    input  logic [NUM_CL-1:0][DATA_W-1:0] cl_data,
    input  logic [NUM_CL-1:0]             cl_seen,
    input  logic [NUM_CL-1:0]             cl_double,
    output logic [DATA_W-1:0]             vote_data,
    output logic                          fix_flag,
    output logic                          fail_flag
);

    sel_mode_e         mode;
    logic [NUM_CL-1:0] clean;
    logic [NUM_CL-1:0] use_mask;
    int                clean_cnt;
    int                use_cnt;
    logic [DATA_W-1:0] split;
    logic [DATA_W-1:0] tie;

    // mode selection from the double-error flags
    always_comb begin
        clean     = ~cl_double;
        clean_cnt = $countones(clean);
        if (clean_cnt == 0)        mode = SEL_NONE;
        else if (clean_cnt >= MAJ) mode = SEL_CLEAN;
        else                       mode = SEL_ALL;
    end

    always_comb begin
        unique case (mode)
            SEL_CLEAN: use_mask = clean;
            SEL_ALL:   use_mask = '1;
            SEL_NONE:  use_mask = '1;
            default:   use_mask = '1;
        endcase
        use_cnt = $countones(use_mask);
    end

    // bitwise vote
    always_comb begin
        for (int b = 0; b < DATA_W; b++) begin
            int ones_use;
            int ones_cl;
            ones_use = 0;
            ones_cl  = 0;
            for (int c = 0; c < NUM_CL; c++) begin
                if (use_mask[c] && cl_data[c][b]) ones_use++;
                if (clean[c] && cl_data[c][b])    ones_cl++;
            end
            vote_data[b] = (2 * ones_use > use_cnt);
            split[b]     = (ones_use != 0) && (ones_use != use_cnt);
            tie[b]       = (clean_cnt != 0) && (2 * ones_cl == clean_cnt);
        end
    end

    assign fail_flag = (mode == SEL_NONE) | (|tie);
    assign fix_flag  = ~fail_flag & ((|cl_seen) | (|split));

endmodule

// File: rtl/penta_link_decoder.sv
module penta_link_decoder
    import penta_dec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM_CL = 5,
    localparam int CHK_W  = check_bits(DATA_W),
    localparam int CW_W   = DATA_W + CHK_W + 1,
    localparam int LINK_W = NUM_CL * CW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [LINK_W-1:0] in_word,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_corrected,
    output logic              out_uncorrectable
);

    logic [NUM_CL-1:0][CW_W-1:0]   cl_word;
    logic [NUM_CL-1:0][DATA_W-1:0] cl_data;
    logic [NUM_CL-1:0]             cl_seen;
    logic [NUM_CL-1:0]             cl_double;
    logic [DATA_W-1:0]             vote_data;
    logic                          fix_flag;
    logic                          fail_flag;

    cluster_splitter #(.NUM_CL(NUM_CL), .CW_W(CW_W)) u_split (
        .link_word (in_word),
        .cl_word   (cl_word)
    );

    for (genvar c = 0; c < NUM_CL; c++) begin : g_dec
        secded_cluster_dec #(.DATA_W(DATA_W)) u_dec (
            .cw       (cl_word[c]),
            .data     (cl_data[c]),
            .err_seen (cl_seen[c]),
            .dbl_err  (cl_double[c])
        );
    end

    cluster_vote_select #(.DATA_W(DATA_W), .NUM_CL(NUM_CL)) u_sel (
        .cl_data   (cl_data),
        .cl_seen   (cl_seen),
        .cl_double (cl_double),
        .vote_data (vote_data),
        .fix_flag  (fix_flag),
        .fail_flag (fail_flag)
    );

    // single output register stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid         <= 1'b0;
            out_data          <= '0;
            out_corrected     <= 1'b0;
            out_uncorrectable <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data          <= vote_data;
                out_corrected     <= fix_flag;
                out_uncorrectable <= fail_flag;
            end else begin
                out_corrected     <= 1'b0;
                out_uncorrectable <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/penta_link_decoder_chk.sv
module penta_link_decoder_chk #(
    parameter int DATA_W = 32,
    parameter int NUM_CL = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_corrected,
    input logic              out_uncorrectable,
    input logic [NUM_CL-1:0] cl_double
);

    assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_flags_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(out_corrected || out_uncorrectable));

    assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));

    assert_no_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (&cl_double)) |=> out_uncorrectable);

    // all five clusters clean: odd count, no tie possible
    assert_all_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(|cl_double)) |=> !out_uncorrectable);

    assert_flag_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_corrected && out_uncorrectable));

endmodule

bind penta_link_decoder penta_link_decoder_chk #(.DATA_W(DATA_W), .NUM_CL(NUM_CL)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .in_valid          (in_valid),
    .out_valid         (out_valid),
    .out_data          (out_data),
    .out_corrected     (out_corrected),
    .out_uncorrectable (out_uncorrectable),
    .cl_double         (cl_double)
);

// File: tb/penta_link_decoder_bench.sv
module penta_link_decoder_bench;

    localparam int DATA_W = 32;
    localparam int NUM_CL = 5;
    localparam int CHK_W  = 6;
    localparam int CW_W   = DATA_W + CHK_W + 1;
    localparam int LINK_W = NUM_CL * CW_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [LINK_W-1:0] in_word = '0;
    logic              out_valid;
    logic [DATA_W-1:0] out_data;
    logic              out_corrected;
    logic              out_uncorrectable;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    penta_link_decoder u_penta_link_decoder (
        .clk               (clk),
        .rst_n             (rst_n),
        .in_valid          (in_valid),
        .in_word           (in_word),
        .out_valid         (out_valid),
        .out_data          (out_data),
        .out_corrected     (out_corrected),
        .out_uncorrectable (out_uncorrectable)
    );

    // extended Hamming encoder built from the R1 layout
    function automatic logic [CW_W-1:0] enc(input logic [DATA_W-1:0] d);
        logic [CW_W-1:0] w;
        int i;
        w = '0;
        i = 0;
        for (int p = 1; p < CW_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                w[p] = d[i];
                i++;
            end
        end
        for (int k = 0; k < CHK_W; k++) begin
            logic x;
            x = 1'b0;
            for (int p = 1; p < CW_W; p++)
                if (((p >> k) & 1) == 1 && p != (1 << k)) x = x ^ w[p];
            w[1 << k] = x;
        end
        w[0] = ^w[CW_W-1:1];
        return w;
    endfunction

    function automatic logic [LINK_W-1:0] weave(input logic [NUM_CL-1:0][CW_W-1:0] cws);
        logic [LINK_W-1:0] w;
        for (int c = 0; c < NUM_CL; c++)
            for (int j = 0; j < CW_W; j++)
                w[j*NUM_CL + c] = cws[c][j];
        return w;
    endfunction

    function automatic logic [LINK_W-1:0] same5(input logic [DATA_W-1:0] d);
        logic [NUM_CL-1:0][CW_W-1:0] cws;
        for (int c = 0; c < NUM_CL; c++) cws[c] = enc(d);
        return weave(cws);
    endfunction

    // flip n distinct bits of cluster c
    function automatic logic [LINK_W-1:0] hit(input logic [LINK_W-1:0] w, input int c, input int n);
        logic [CW_W-1:0] used;
        used = '0;
        for (int e = 0; e < n; e++) begin
            int j;
            do j = int'($urandom % CW_W); while (used[j]);
            used[j] = 1'b1;
            w[j*NUM_CL + c] = ~w[j*NUM_CL + c];
        end
        return w;
    endfunction

    // double error on check positions 1 and 2 of cluster c (data bits intact)
    function automatic logic [LINK_W-1:0] dbl(input logic [LINK_W-1:0] w, input int c);
        w[1*NUM_CL + c] = ~w[1*NUM_CL + c];
        w[2*NUM_CL + c] = ~w[2*NUM_CL + c];
        return w;
    endfunction

    task automatic apply(input logic [LINK_W-1:0] word, input bit chk_d,
                         input logic [DATA_W-1:0] exp_d, input logic exp_c,
                         input logic exp_u, input string tag);
        @(negedge clk);
        in_word  = word;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        compared++;
        if (out_valid !== 1'b1 || (chk_d && out_data !== exp_d) ||
            out_corrected !== exp_c || out_uncorrectable !== exp_u) begin
            mismatched++;
            $display("FAIL %s: valid=%b data=%h corr=%b unc=%b / expected valid=1 data=%h corr=%b unc=%b",
                     tag, out_valid, out_data, out_corrected, out_uncorrectable,
                     exp_d, exp_c, exp_u);
        end
    endtask

    initial begin
        logic [DATA_W-1:0] x_d;
        logic [DATA_W-1:0] y_d;
        logic [DATA_W-1:0] z_d;
        logic [DATA_W-1:0] held;
        logic [LINK_W-1:0] w;
        logic [NUM_CL-1:0][CW_W-1:0] cws;
        int seed;
        seed = int'($urandom(32'd20240611));
        x_d = 32'hA5A5_0F0F;
        y_d = 32'h5A5A_F0F0;
        z_d = 32'h1234_5678;

        // reset state (R2)
        repeat (3) @(negedge clk);
        compared++;
        if (out_valid !== 1'b0 || out_data !== '0 || out_corrected !== 1'b0 || out_uncorrectable !== 1'b0) begin
            mismatched++;
            $display("FAIL R2 reset: valid=%b data=%h corr=%b unc=%b / expected all zero",
                     out_valid, out_data, out_corrected, out_uncorrectable);
        end
        rst_n = 1'b1;

        // R1 and R11: clean words
        apply(same5(32'h0000_0000), 1, 32'h0000_0000, 0, 0, "R1 zero");
        apply(same5(32'hFFFF_FFFF), 1, 32'hFFFF_FFFF, 0, 0, "R1 ones");
        apply(same5(x_d), 1, x_d, 0, 0, "R11 clean");
        for (int t = 0; t < 8; t++) begin
            logic [DATA_W-1:0] d;
            d = $urandom;
            apply(same5(d), 1, d, 0, 0, "R1 random clean");
        end

        // R2: idle cycle keeps data, drops valid and flags
        held = x_d ^ 32'h0000_0001;
        apply(hit(same5(held), 0, 1), 1, held, 1, 0, "R3 before idle");
        @(negedge clk);
        compared++;
        if (out_valid !== 1'b0 || out_data !== held || out_corrected !== 1'b0 || out_uncorrectable !== 1'b0) begin
            mismatched++;
            $display("FAIL R2 idle: valid=%b data=%h corr=%b unc=%b / expected valid=0 data=%h corr=0 unc=0",
                     out_valid, out_data, out_corrected, out_uncorrectable, held);
        end

        // R3: every single wire
        for (int wi = 0; wi < LINK_W; wi++) begin
            logic [DATA_W-1:0] d;
            d = $urandom;
            w = same5(d);
            w[wi] = ~w[wi];
            apply(w, 1, d, 1, 0, "R3 single wire");
        end

        // R4: three adjacent wires at every start
        for (int s = 0; s + 2 < LINK_W; s++) begin
            logic [DATA_W-1:0] d;
            d = $urandom;
            w = same5(d);
            w[s] = ~w[s];
            w[s+1] = ~w[s+1];
            w[s+2] = ~w[s+2];
            apply(w, 1, d, 1, 0, "R4 burst");
        end

        // R5: one cluster with two errors, another with one
        w = hit(hit(same5(z_d), 1, 2), 0, 1);
        apply(w, 1, z_d, 1, 0, "R5 double plus single");
        w = hit(hit(same5(y_d), 3, 2), 4, 2);
        apply(w, 1, y_d, 1, 0, "R5 two doubles");

        // R6: directed nine errors (7 + 2 + 0 + 0 + 0)
        w = hit(hit(same5(x_d), 2, 7), 4, 2);
        apply(w, 1, x_d, 1, 0, "R6 nine directed");

        // R6: random patterns of up to nine errors
        for (int t = 0; t < 400; t++) begin
            logic [DATA_W-1:0] d;
            int kc [NUM_CL];
            int h;
            int m;
            int tot;
            d = $urandom;
            h = int'($urandom % NUM_CL);
            m = (h + 1 + int'($urandom % (NUM_CL - 1))) % NUM_CL;
            for (int c = 0; c < NUM_CL; c++) kc[c] = int'($urandom % 2);
            kc[h] = int'($urandom % 8);
            kc[m] = int'($urandom % 3);
            tot = 0;
            for (int c = 0; c < NUM_CL; c++) tot += kc[c];
            if (tot > 9) begin
                kc[h] = kc[h] - (tot - 9);
                tot = 9;
            end
            w = same5(d);
            for (int c = 0; c < NUM_CL; c++) w = hit(w, c, kc[c]);
            apply(w, 1, d, (tot > 0), 0, "R6 random");
        end

        // R7: clean clusters outvote, no code errors
        cws[0] = enc(x_d); cws[1] = enc(x_d); cws[2] = enc(x_d);
        cws[3] = enc(y_d); cws[4] = enc(y_d);
        apply(weave(cws), 1, x_d, 1, 0, "R7 split clean vote");

        // R8: two clean clusters, fallback over all five
        cws[0] = enc(x_d); cws[1] = enc(x_d);
        cws[2] = enc(z_d); cws[3] = enc(z_d); cws[4] = enc(z_d);
        w = dbl(dbl(dbl(weave(cws), 2), 3), 4);
        apply(w, 1, z_d, 1, 0, "R8 fallback vote");

        // R9: every cluster double
        w = same5(x_d);
        for (int c = 0; c < NUM_CL; c++) w = dbl(w, c);
        apply(w, 0, '0, 0, 1, "R9 all double");

        // R10: four clean clusters tied
        cws[0] = enc(x_d); cws[1] = enc(x_d);
        cws[2] = enc(y_d); cws[3] = enc(y_d); cws[4] = enc(z_d);
        apply(dbl(weave(cws), 4), 0, '0, 0, 1, "R10 four-way tie");

        // R10: two clean clusters disagree
        cws[0] = enc(x_d); cws[1] = enc(y_d);
        cws[2] = enc(z_d); cws[3] = enc(z_d); cws[4] = enc(z_d);
        w = dbl(dbl(dbl(weave(cws), 2), 3), 4);
        apply(w, 0, '0, 0, 1, "R10 two clean disagree");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL R2 watchdog: run still active after 150000 cycles / expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule